// File: doc/BRIEF.md
# Integer Execute Unit with Instruction-Field Decode

This block is the combinational integer execute stage of a 32-bit RISC pipeline. It receives the two register operands, the 16-bit immediate, the 5-bit shift amount and the 6-bit major opcode and 6-bit function fields of the instruction word. It turns those fields directly into one operation, computes a 32-bit result, and reports a trap on signed overflow. It also flags encodings it does not implement.

The block covers register-register and register-immediate arithmetic, bitwise logic, compare-to-flag operations, shifts by a constant amount, and the upper-immediate load. It widens the immediate by sign or zero extension, depending on the operation. A write-permission output tells the register file stage whether the destination may be updated. This output is held low when the operation traps or is not recognised.

The block has no storage. It has three stages of logic, all combinational: a field decoder, an immediate widener and an arithmetic core.

Top module: `int_exec_unit`

## Requirements
- R1: With opcode 0x00, function 0x20 (add) and 0x21 (add, non-trapping) give opnd_a + opnd_b, and 0x22 (subtract) and 0x23 (subtract, non-trapping) give opnd_a - opnd_b. All four results wrap modulo 2^32.
- R2: With opcode 0x00, function 0x24 gives the bitwise AND of the operands, 0x25 gives the bitwise OR, and 0x27 gives the inverse of the OR.
- R3: With opcode 0x00, function 0x2a gives 1 when opnd_a < opnd_b as two's-complement numbers, and 0 otherwise. Function 0x2b does the same compare on unsigned numbers. Bits 31:1 of the result are zero for both.
- R4: With opcode 0x00, function 0x00 shifts opnd_b left by shamt and 0x02 shifts it right logically by shamt. Function 0x03 shifts it right arithmetically by shamt.
- R5: For opcodes 0x08 (add immediate), 0x09 (add immediate, non-trapping), 0x0a (signed compare immediate) and 0x0b (unsigned compare immediate), the second operand is the immediate sign-extended from bit 15. Opcode 0x0b still compares unsigned.
- R6: Opcode 0x0c gives opnd_a AND the zero-extended immediate. Opcode 0x0d gives opnd_a OR the zero-extended immediate.
- R7: Opcode 0x0f gives the immediate in bits 31:16 and zeros in bits 15:0.
- R8: ovf_trap is set only for add (0x00/0x20), subtract (0x00/0x22) and add immediate (0x08), and only on signed overflow. For add, overflow means the operands share a sign and the sum's sign differs from it. For subtract, it means the operand signs differ and the difference's sign differs from opnd_a.
- R9: wr_en is high exactly when the encoding is legal and ovf_trap is low. On overflow, result still carries the wrapped value.
- R10: Any opcode other than those above, or opcode 0x00 with any other function code, sets illegal_op and drives result to 0 with ovf_trap low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First source operand |
| opnd_b | input | 32 | Second source operand (register form) |
| imm16 | input | 16 | Immediate field |
| shamt | input | 5 | Constant shift amount |
| opcode | input | 6 | Major opcode field |
| funct | input | 6 | Function field, used when opcode is 0 |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_en | output | 1 | Destination write permitted |
| illegal_op | output | 1 | Unrecognised opcode/function combination |

## Verification
The embedded checks evaluate after the combinational logic settles. They take for granted that every input carries a known 0/1 value and that the inputs stay stable while a result is read. The bench drives all inputs together, half a clock away from the sampling point, and only with fully defined values. Stimulus mixes legal encodings, chosen from the implemented set with random operands, and fully random opcode/function pairs that reach the illegal path. Directed operands sit at the sign boundaries where overflow and signed/unsigned compares diverge.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_NOR,
        K_SLT, K_SLTU, K_SLL, K_SRL, K_SRA,
        K_LUI, K_NONE
    } exu_kind_e;

    typedef struct packed {
        exu_kind_e kind;
        logic      use_imm;
        logic      zext;
        logic      trap_en;
        logic      bad;
    } exu_ctl_t;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_ADDI    = 6'h08;
    localparam logic [5:0] OPC_ADDIU   = 6'h09;
    localparam logic [5:0] OPC_SLTI    = 6'h0a;
    localparam logic [5:0] OPC_SLTIU   = 6'h0b;
    localparam logic [5:0] OPC_ANDI    = 6'h0c;
    localparam logic [5:0] OPC_ORI     = 6'h0d;
    localparam logic [5:0] OPC_LUI     = 6'h0f;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_NOR  = 6'h27;
    localparam logic [5:0] FN_SLT  = 6'h2a;
    localparam logic [5:0] FN_SLTU = 6'h2b;

endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
    import iexu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output exu_ctl_t   ctl
);

    exu_ctl_t rtype;

    always_comb begin
        rtype = '{kind: K_NONE, use_imm: 1'b0, zext: 1'b0, trap_en: 1'b0, bad: 1'b0};
        unique case (funct)
            FN_ADD:  begin rtype.kind = K_ADD; rtype.trap_en = 1'b1; end
            FN_ADDU: rtype.kind = K_ADD;
            FN_SUB:  begin rtype.kind = K_SUB; rtype.trap_en = 1'b1; end
            FN_SUBU: rtype.kind = K_SUB;
            FN_AND:  rtype.kind = K_AND;
            FN_OR:   rtype.kind = K_OR;
            FN_NOR:  rtype.kind = K_NOR;
            FN_SLT:  rtype.kind = K_SLT;
            FN_SLTU: rtype.kind = K_SLTU;
            FN_SLL:  rtype.kind = K_SLL;
            FN_SRL:  rtype.kind = K_SRL;
            FN_SRA:  rtype.kind = K_SRA;
            default: rtype.bad = 1'b1;
        endcase
    end

    always_comb begin
        ctl = '{kind: K_NONE, use_imm: 1'b1, zext: 1'b0, trap_en: 1'b0, bad: 1'b0};
        unique case (opcode)
            OPC_SPECIAL: ctl = rtype;
            OPC_ADDI:    begin ctl.kind = K_ADD; ctl.trap_en = 1'b1; end
            OPC_ADDIU:   ctl.kind = K_ADD;
            OPC_SLTI:    ctl.kind = K_SLT;
            OPC_SLTIU:   ctl.kind = K_SLTU;
            OPC_ANDI:    begin ctl.kind = K_AND; ctl.zext = 1'b1; end
            OPC_ORI:     begin ctl.kind = K_OR;  ctl.zext = 1'b1; end
            OPC_LUI:     ctl.kind = K_LUI;
            default:     begin ctl.bad = 1'b1; ctl.use_imm = 1'b0; end
        endcase
    end

endmodule

// File: rtl/iexu_immext.sv
module iexu_immext #(
    parameter int IMM_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              zext,
    output logic [DATA_W-1:0] wide
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic fill;

    always_comb begin
        fill = zext ? 1'b0 : imm[IMM_W-1];
        wide = {{PAD_W{fill}}, imm};
    end

endmodule

// File: rtl/iexu_core.sv
module iexu_core
    import iexu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SH_W   = 5,
    parameter int IMM_W  = 16
) (
    input  exu_ctl_t          ctl,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [SH_W-1:0]   sh,
    output logic [DATA_W-1:0] res,
    output logic              ovf
);

    localparam int MSB = DATA_W - 1;
    localparam int LO_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] sum, diff;
    logic              add_ov, sub_ov;

    always_comb begin
        sum    = a + b;
        diff   = a - b;
        add_ov = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
        sub_ov = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);
    end

    always_comb begin
        res = '0;
        ovf = 1'b0;
        unique case (ctl.kind)
            K_ADD:  begin res = sum;  ovf = ctl.trap_en & add_ov; end
            K_SUB:  begin res = diff; ovf = ctl.trap_en & sub_ov; end
            K_AND:  res = a & b;
            K_OR:   res = a | b;
            K_NOR:  res = ~(a | b);
            K_SLT:  res = {{MSB{1'b0}}, ($signed(a) < $signed(b))};
            K_SLTU: res = {{MSB{1'b0}}, (a < b)};
            K_SLL:  res = b << sh;
            K_SRL:  res = b >> sh;
            K_SRA:  res = $unsigned($signed(b) >>> sh);
            K_LUI:  res = {imm, {LO_W{1'b0}}};
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int SH_W   = 5
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [SH_W-1:0]   shamt,
    input  logic [5:0]        opcode,
    input  logic [5:0]        funct,
    output logic [DATA_W-1:0] result,
    output logic              ovf_trap,
    output logic              wr_en,
    output logic              illegal_op
);

    exu_ctl_t          ctl;
    logic [DATA_W-1:0] imm_wide;
    logic [DATA_W-1:0] src_b;
    logic [DATA_W-1:0] core_res;
    logic              core_ovf;

    iexu_decode u_dec (
        .opcode (opcode),
        .funct  (funct),
        .ctl    (ctl)
    );

    iexu_immext #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_ext (
        .imm  (imm16),
        .zext (ctl.zext),
        .wide (imm_wide)
    );

    always_comb src_b = ctl.use_imm ? imm_wide : opnd_b;

    iexu_core #(.DATA_W(DATA_W), .SH_W(SH_W), .IMM_W(IMM_W)) u_core (
        .ctl (ctl),
        .a   (opnd_a),
        .b   (src_b),
        .imm (imm16),
        .sh  (shamt),
        .res (core_res),
        .ovf (core_ovf)
    );

    always_comb begin
        result     = ctl.bad ? '0 : core_res;
        ovf_trap   = core_ovf & ~ctl.bad;
        illegal_op = ctl.bad;
        wr_en      = ~ctl.bad & ~core_ovf;
    end

    always_comb begin
        // R8
        no_overflow_chk: assert final (!(ovf_trap && !ctl.trap_en));
        // R9
        wr_gate_chk: assert final (!(wr_en && (illegal_op || ovf_trap)));
        // R3
        slt_bool_chk: assert final (!((ctl.kind == K_SLT || ctl.kind == K_SLTU) && !ctl.bad)
                                    || (result[DATA_W-1:1] == '0));
        // R7
        lui_low_chk: assert final (!(opcode == OPC_LUI) || (result[DATA_W-IMM_W-1:0] == '0));
        // R10
        illegal_zero_chk: assert final (!illegal_op || (result == '0 && !ovf_trap));
    end

endmodule

// File: tb/sim_int_exec_unit.sv
module sim_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a, opnd_b, result;
    logic [15:0] imm16;
    logic [4:0]  shamt;
    logic [5:0]  opcode, funct;
    logic        ovf_trap, wr_en, illegal_op;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    int_exec_unit u0 (
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm16(imm16), .shamt(shamt),
        .opcode(opcode), .funct(funct), .result(result),
        .ovf_trap(ovf_trap), .wr_en(wr_en), .illegal_op(illegal_op)
    );

    function automatic void model(
        input  logic [5:0] op, input logic [5:0] fn,
        input  logic [31:0] a, input logic [31:0] b,
        input  logic [15:0] im, input logic [4:0] sh,
        output logic [31:0] r, output logic ov, output logic il);
        logic [31:0] se, ze, s, d;
        se = {{16{im[15]}}, im};
        ze = {16'h0, im};
        r = 32'h0; ov = 1'b0; il = 1'b0;
        if (op == 6'h00) begin
            s = a + b; d = a - b;
            case (fn)
                6'h20: begin r = s; ov = (a[31] == b[31]) && (s[31] != a[31]); end
                6'h21: r = s;
                6'h22: begin r = d; ov = (a[31] != b[31]) && (d[31] != a[31]); end
                6'h23: r = d;
                6'h24: r = a & b;
                6'h25: r = a | b;
                6'h27: r = ~(a | b);
                6'h2a: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                6'h2b: r = (a < b) ? 32'd1 : 32'd0;
                6'h00: r = b << sh;
                6'h02: r = b >> sh;
                6'h03: r = $unsigned($signed(b) >>> sh);
                default: il = 1'b1;
            endcase
        end else begin
            s = a + se;
            case (op)
                6'h08: begin r = s; ov = (a[31] == se[31]) && (s[31] != a[31]); end
                6'h09: r = s;
                6'h0a: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
                6'h0b: r = (a < se) ? 32'd1 : 32'd0;
                6'h0c: r = a & ze;
                6'h0d: r = a | ze;
                6'h0f: r = {im, 16'h0};
                default: il = 1'b1;
            endcase
        end
    endfunction

    task automatic apply(input string tag, input logic [5:0] op, input logic [5:0] fn,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [15:0] im, input logic [4:0] sh);
        logic [31:0] er;
        logic eo, ei, ew;
        @(negedge clk);
        opcode = op; funct = fn; opnd_a = a; opnd_b = b; imm16 = im; shamt = sh;
        model(op, fn, a, b, im, sh, er, eo, ei);
        ew = !ei && !eo;
        @(posedge clk);
        n_run++;
        if (result !== er || ovf_trap !== eo || illegal_op !== ei || wr_en !== ew) begin
            n_fail++;
            $display("FAIL %s op=%h fn=%h a=%h b=%h imm=%h sh=%0d: got r=%h ov=%b il=%b we=%b exp r=%h ov=%b il=%b we=%b",
                     tag, op, fn, a, b, im, sh, result, ovf_trap, illegal_op, wr_en, er, eo, ei, ew);
        end
    endtask

    localparam logic [5:0] FNS [12] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25,
                                         6'h27, 6'h2a, 6'h2b, 6'h00, 6'h02, 6'h03};
    localparam logic [5:0] OPS [7]  = '{6'h08, 6'h09, 6'h0a, 6'h0b, 6'h0c, 6'h0d, 6'h0f};

    initial begin
        #400000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] op, fn;
        void'($urandom(32'd20240611));
        opcode = 0; funct = 0; opnd_a = 0; opnd_b = 0; imm16 = 0; shamt = 0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // reset-state style check: all-zero word is shift of zero (R4)
        apply("R4", 6'h00, 6'h00, 32'h0, 32'h0, 16'h0, 5'd0);
        // R1 / R8 / R9 directed sign boundaries
        apply("R8", 6'h00, 6'h20, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        apply("R1", 6'h00, 6'h21, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        apply("R8", 6'h00, 6'h22, 32'h80000000, 32'h1, 16'h0, 5'd0);
        apply("R1", 6'h00, 6'h23, 32'h80000000, 32'h1, 16'h0, 5'd0);
        apply("R9", 6'h00, 6'h20, 32'h80000000, 32'h80000000, 16'h0, 5'd0);
        apply("R8", 6'h08, 6'h00, 32'h80000000, 32'h0, 16'h8000, 5'd0);
        apply("R5", 6'h09, 6'h00, 32'h80000000, 32'h0, 16'h8000, 5'd0);
        // R2
        apply("R2", 6'h00, 6'h27, 32'h0f0f0000, 32'h000000f0, 16'h0, 5'd0);
        // R3 signed vs unsigned
        apply("R3", 6'h00, 6'h2a, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        apply("R3", 6'h00, 6'h2b, 32'hffffffff, 32'h1, 16'h0, 5'd0);
        // R5 unsigned compare with sign-extended immediate
        apply("R5", 6'h0b, 6'h00, 32'h5, 32'h0, 16'hffff, 5'd0);
        apply("R5", 6'h0a, 6'h00, 32'h5, 32'h0, 16'hffff, 5'd0);
        // R6 zero extension
        apply("R6", 6'h0c, 6'h00, 32'hffffffff, 32'h0, 16'hffff, 5'd0);
        apply("R6", 6'h0d, 6'h00, 32'h12340000, 32'h0, 16'h8001, 5'd0);
        // R7
        apply("R7", 6'h0f, 6'h00, 32'hdeadbeef, 32'h0, 16'hbeef, 5'd0);
        // R4 shifts
        apply("R4", 6'h00, 6'h00, 32'h0, 32'h80000001, 16'h0, 5'd31);
        apply("R4", 6'h00, 6'h02, 32'h0, 32'h80000000, 16'h0, 5'd4);
        apply("R4", 6'h00, 6'h03, 32'h0, 32'h80000000, 16'h0, 5'd4);
        // R10 illegal encodings
        apply("R10", 6'h3f, 6'h20, 32'h1, 32'h1, 16'h1, 5'd0);
        apply("R10", 6'h00, 6'h01, 32'h7fffffff, 32'h1, 16'h0, 5'd0);
        apply("R10", 6'h0e, 6'h00, 32'h1, 32'h1, 16'hffff, 5'd0);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 5) begin
                op = 6'h00; fn = FNS[$urandom_range(0, 11)];
            end else if (sel < 8) begin
                op = OPS[$urandom_range(0, 6)]; fn = 6'($urandom);
            end else begin
                op = 6'($urandom); fn = 6'($urandom);
            end
            apply("R1", op, fn, $urandom, $urandom, 16'($urandom), 5'($urandom));
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule